// File: doc/BRIEF.md
# Two-Wire PLL Programming Receiver

This block is a write-only slave on a two-wire CLOCK/DATA bus that programs a pair of frequency synthesizers. A fast system clock oversamples both bus lines. The block finds start and stop conditions and accepts a transfer only when the address byte matches a value set by a 2-bit select input. It acknowledges by pulling DATA low, and it collects data bytes in groups of three to form 24-bit programming words.

Each complete word is written at once into one of four registers: the reference divider or the main divider of either synthesizer. The two lowest bits of the word choose the register. The block's outputs are the decoded divider fields, which feed the synthesizer counters and phase detectors directly. DATA is open-drain. The block never drives it high. It only asserts a pull-low enable.

Top module: `pll2w_slave`

## Requirements
- R1: After reset every decoded field output is 0 and the DATA pull-low enable is deasserted.
- R2: A start is a falling DATA edge while CLOCK is high, and a stop is a rising DATA edge while CLOCK is high. After a stop, the block returns no acknowledge until a new start is seen, even if CLOCK keeps toggling.
- R3: The first byte after a start is the address, received MSB first. It matches only when it equals {5'b11000, sel[1], sel[0], 1'b0}, so 0xC0, 0xC2, 0xC4 or 0xC6 for a select of 0 to 3. A matching address is acknowledged by holding DATA low across the ninth clock pulse.
- R4: A non-matching address gets no acknowledge. Every later byte up to the next start gets no acknowledge and changes no register.
- R5: After a matching address, every data byte is acknowledged on its ninth clock pulse.
- R6: Each three data bytes form one word, numbered 23..0, and the first byte carries bits 23:16. The word is committed as soon as its third byte has been shifted in, with no wait for a stop. A single transfer may carry several words back to back.
- R7: Word bits 1:0 choose the destination: 00 is PLL2 reference, 01 is PLL2 main, 10 is PLL1 reference and 11 is PLL1 main. Only that register changes.
- R8: In a reference word, bit 17 is the phase-detector polarity and bits 16:2 are the 15-bit R divide ratio. Bits 23:18 do not affect any output.
- R9: In a main word, bit 20 is the prescaler mode (0 means 64/65), bits 19:9 are the 11-bit B count and bits 8:2 are the 7-bit A count. Bits 23:21 do not affect any output.
- R10: A start or repeated start in mid-transfer throws away any partial byte and any partial word, and the next byte is treated as an address.
- R11: The pull-low enable changes only while the synchronized CLOCK is low. It is asserted at the CLOCK fall that ends the eighth bit and released at the fall that ends the ninth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Bus CLOCK line (asynchronous) |
| bus_data_i | input | 1 | Bus DATA line as seen on the wire (asynchronous) |
| addr_sel_i | input | 2 | Address select; sets bits 2:1 of the expected address |
| bus_data_pull_o | output | 1 | Open-drain enable: 1 pulls DATA low |
| pll1_ref_pol_o | output | 1 | PLL1 phase-detector polarity |
| pll1_ref_div_o | output | 15 | PLL1 reference divide ratio |
| pll1_presc_mode_o | output | 1 | PLL1 prescaler mode |
| pll1_b_cnt_o | output | 11 | PLL1 main divider B count |
| pll1_a_cnt_o | output | 7 | PLL1 main divider A count |
| pll2_ref_pol_o | output | 1 | PLL2 phase-detector polarity |
| pll2_ref_div_o | output | 15 | PLL2 reference divide ratio |
| pll2_presc_mode_o | output | 1 | PLL2 prescaler mode |
| pll2_b_cnt_o | output | 11 | PLL2 main divider B count |
| pll2_a_cnt_o | output | 7 | PLL2 main divider A count |

## Verification
The assertions check the following on every cycle:
- The pull-low enable moves only while CLOCK is low and is released on a CLOCK fall.
- The enable is clear right after a stop.
- At most one register loads at a time, and no field changes without a commit.
- A start empties the word assembler.

The directed scenarios are the only way to show the rest:
- address matching for each select value;
- the bit positions of each field;
- routing by the select bits;
- silence after a mismatched address or after a stop;
- that a repeated start in mid-word leaves no fragment behind.

// File: rtl/pll2w_pkg.sv
package pll2w_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_PLL  = 2;
    localparam int NUM_REG  = 2 * NUM_PLL;
    localparam int RDIV_W   = 15;
    localparam int BCNT_W   = 11;
    localparam int ACNT_W   = 7;
    localparam int HI_KEEP  = 5;   // low bits of the first byte that carry fields
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_DATA,
        LK_ACK,
        LK_SKIP
    } link_state_t;

    typedef struct packed {
        logic              pol;
        logic [RDIV_W-1:0] div;
    } ref_fields_t;

    typedef struct packed {
        logic              presc;
        logic [BCNT_W-1:0] bcnt;
        logic [ACNT_W-1:0] acnt;
    } main_fields_t;

    function automatic logic [BYTE_W-1:0] dev_addr(input logic [1:0] sel);
        return {5'b11000, sel, 1'b0};
    endfunction

    // hi: word[20:16], mid: word[15:8], lo: word[7:0]
    function automatic ref_fields_t take_ref(input logic [HI_KEEP-1:0] hi,
                                             input logic [BYTE_W-1:0]  mid,
                                             input logic [BYTE_W-1:0]  lo);
        ref_fields_t r;
        r.pol = hi[1];
        r.div = {hi[0], mid, lo[7:2]};
        return r;
    endfunction

    function automatic main_fields_t take_main(input logic [HI_KEEP-1:0] hi,
                                               input logic [BYTE_W-1:0]  mid,
                                               input logic [BYTE_W-1:0]  lo);
        main_fields_t m;
        m.presc = hi[4];
        m.bcnt  = {hi[3:0], mid[7:1]};
        m.acnt  = {mid[0], lo[7:2]};
        return m;
    endfunction

endpackage

// File: rtl/pll2w_sync.sv
module pll2w_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '1;
                else if (s == 0) stg[s] <= d_i;
                else stg[s] <= stg[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= stg[STAGES-1];
    end

    assign lvl_o  = stg[STAGES-1];
    assign rise_o = stg[STAGES-1] & ~prev;
    assign fall_o = prev & ~stg[STAGES-1];
endmodule

// File: rtl/pll2w_link.sv
module pll2w_link
    import pll2w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [1:0]        sel_i,
    output logic              pull_o,
    output logic              start_o,
    output logic              stop_o,
    output logic              byte_o,
    output logic [BYTE_W-1:0] data_o
);
    link_state_t       st;
    logic [CNT_W-1:0]  bits;

    assign start_o = scl_lvl & sda_fall;
    assign stop_o  = scl_lvl & sda_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= LK_IDLE;
            bits   <= '0;
            pull_o <= 1'b0;
            byte_o <= 1'b0;
            data_o <= '0;
        end else begin
            byte_o <= 1'b0;
            if (start_o) begin
                st     <= LK_ADDR;
                bits   <= '0;
                pull_o <= 1'b0;
            end else if (stop_o) begin
                st     <= LK_IDLE;
                pull_o <= 1'b0;
            end else begin
                unique case (st)
                    LK_ADDR, LK_DATA: begin
                        if (scl_rise) begin
                            data_o <= {data_o[BYTE_W-2:0], sda_lvl};
                            bits   <= bits + 1'b1;
                        end else if (scl_fall && bits == CNT_W'(BYTE_W)) begin
                            bits <= '0;
                            if (st == LK_DATA) begin
                                byte_o <= 1'b1;
                                pull_o <= 1'b1;
                                st     <= LK_ACK;
                            end else if (data_o == dev_addr(sel_i)) begin
                                pull_o <= 1'b1;
                                st     <= LK_ACK;
                            end else begin
                                st <= LK_SKIP;
                            end
                        end
                    end
                    LK_ACK: begin
                        if (scl_fall) begin
                            pull_o <= 1'b0;
                            st     <= LK_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pll2w_bank.sv
module pll2w_bank
    import pll2w_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clear_i,
    input  logic                              byte_i,
    input  logic [BYTE_W-1:0]                 data_i,
    output ref_fields_t  [NUM_PLL-1:0]        ref_q,
    output main_fields_t [NUM_PLL-1:0]        main_q,
    output logic                              commit_o,
    output logic [NUM_REG-1:0]                load_o,
    output logic [1:0]                        idx_o
);
    logic [HI_KEEP-1:0] hi;
    logic [BYTE_W-1:0]  mid;
    ref_fields_t        nxt_ref;
    main_fields_t       nxt_main;

    always_comb begin
        commit_o = byte_i && !clear_i && (idx_o == 2'd2);
        load_o   = commit_o ? (NUM_REG'(1) << data_i[1:0]) : '0;
        nxt_ref  = take_ref(hi, mid, data_i);
        nxt_main = take_main(hi, mid, data_i);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            idx_o <= 2'd0;
        end else if (byte_i) begin
            unique case (idx_o)
                2'd0: begin hi  <= data_i[HI_KEEP-1:0]; idx_o <= 2'd1; end
                2'd1: begin mid <= data_i;              idx_o <= 2'd2; end
                default: idx_o <= 2'd0;
            endcase
        end
    end

    // slot p: p=0 holds PLL2 (select 0x), p=1 holds PLL1 (select 1x)
    generate
        for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
            always_ff @(posedge clk) begin
                if (rst) begin
                    ref_q[p]  <= '0;
                    main_q[p] <= '0;
                end else begin
                    if (load_o[2*p])   ref_q[p]  <= nxt_ref;
                    if (load_o[2*p+1]) main_q[p] <= nxt_main;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pll2w_slave.sv
module pll2w_slave
    import pll2w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_clk_i,
    input  logic              bus_data_i,
    input  logic [1:0]        addr_sel_i,
    output logic              bus_data_pull_o,
    output logic              pll1_ref_pol_o,
    output logic [RDIV_W-1:0] pll1_ref_div_o,
    output logic              pll1_presc_mode_o,
    output logic [BCNT_W-1:0] pll1_b_cnt_o,
    output logic [ACNT_W-1:0] pll1_a_cnt_o,
    output logic              pll2_ref_pol_o,
    output logic [RDIV_W-1:0] pll2_ref_div_o,
    output logic              pll2_presc_mode_o,
    output logic [BCNT_W-1:0] pll2_b_cnt_o,
    output logic [ACNT_W-1:0] pll2_a_cnt_o
);
    logic [1:0] s_lvl, s_rise, s_fall;   // [1]=CLOCK, [0]=DATA
    logic       scl_s, scl_fall;
    logic       start_p, stop_p, byte_p;
    logic [BYTE_W-1:0] byte_d;
    logic       commit;
    logic [NUM_REG-1:0] load_vec;
    logic [1:0] byte_idx;
    ref_fields_t  [NUM_PLL-1:0] refs;
    main_fields_t [NUM_PLL-1:0] mains;

    pll2w_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i({bus_clk_i, bus_data_i}),
        .lvl_o(s_lvl), .rise_o(s_rise), .fall_o(s_fall)
    );

    assign scl_s    = s_lvl[1];
    assign scl_fall = s_fall[1];

    pll2w_link u_link (
        .clk(clk), .rst(rst),
        .scl_lvl(scl_s), .scl_rise(s_rise[1]), .scl_fall(scl_fall),
        .sda_lvl(s_lvl[0]), .sda_rise(s_rise[0]), .sda_fall(s_fall[0]),
        .sel_i(addr_sel_i), .pull_o(bus_data_pull_o),
        .start_o(start_p), .stop_o(stop_p), .byte_o(byte_p), .data_o(byte_d)
    );

    pll2w_bank u_bank (
        .clk(clk), .rst(rst), .clear_i(start_p | stop_p),
        .byte_i(byte_p), .data_i(byte_d),
        .ref_q(refs), .main_q(mains),
        .commit_o(commit), .load_o(load_vec), .idx_o(byte_idx)
    );

    assign pll2_ref_pol_o    = refs[0].pol;
    assign pll2_ref_div_o    = refs[0].div;
    assign pll2_presc_mode_o = mains[0].presc;
    assign pll2_b_cnt_o      = mains[0].bcnt;
    assign pll2_a_cnt_o      = mains[0].acnt;
    assign pll1_ref_pol_o    = refs[1].pol;
    assign pll1_ref_div_o    = refs[1].div;
    assign pll1_presc_mode_o = mains[1].presc;
    assign pll1_b_cnt_o      = mains[1].bcnt;
    assign pll1_a_cnt_o      = mains[1].acnt;
endmodule

// File: rtl/pll2w_slave_chk.sv
module pll2w_slave_chk #(
    parameter int FIELD_W = 70
) (
    input logic               clk,
    input logic               rst,
    input logic               scl_s,
    input logic               scl_fall,
    input logic               start_p,
    input logic               stop_p,
    input logic               commit,
    input logic [3:0]         load_vec,
    input logic [1:0]         byte_idx,
    input logic               pull,
    input logic [FIELD_W-1:0] fields
);
    // R11: pull-low enable asserted only while CLOCK is low
    a_r11_pull_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(pull) |-> !scl_s);

    // R11: release happens at a CLOCK fall (or on a bus condition)
    a_r11_release_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(pull) |-> ($past(scl_fall) || $past(start_p) || $past(stop_p)));

    // R2: no acknowledge drive right after a stop
    a_r2_quiet_after_stop: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> !pull);

    // R7: at most one destination register loads
    a_r7_single_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));

    // R6: fields hold unless a word commits
    a_r6_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(fields));

    // R10: a start empties the word assembler
    a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_p |=> (byte_idx == 2'd0));
endmodule

bind pll2w_slave pll2w_slave_chk #(.FIELD_W(70)) u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .commit(commit),
    .load_vec(load_vec), .byte_idx(byte_idx), .pull(bus_data_pull_o),
    .fields({pll1_ref_pol_o, pll1_ref_div_o, pll1_presc_mode_o, pll1_b_cnt_o,
             pll1_a_cnt_o, pll2_ref_pol_o, pll2_ref_div_o, pll2_presc_mode_o,
             pll2_b_cnt_o, pll2_a_cnt_o})
);

// File: tb/pll2w_slave_bench.sv
module pll2w_slave_bench;
    localparam int HALF = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] sel = 2'd0;
    logic pull;
    wire  bus_sda = m_sda & ~pull;

    logic        p1_pol, p2_pol, p1_ps, p2_ps;
    logic [14:0] p1_r, p2_r;
    logic [10:0] p1_b, p2_b;
    logic [6:0]  p1_a, p2_a;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit pre_ack_pull;

    always #4 clk = ~clk;

    pll2w_slave u_pll2w_slave (
        .clk(clk), .rst(rst), .bus_clk_i(m_scl), .bus_data_i(bus_sda),
        .addr_sel_i(sel), .bus_data_pull_o(pull),
        .pll1_ref_pol_o(p1_pol), .pll1_ref_div_o(p1_r), .pll1_presc_mode_o(p1_ps),
        .pll1_b_cnt_o(p1_b), .pll1_a_cnt_o(p1_a),
        .pll2_ref_pol_o(p2_pol), .pll2_ref_div_o(p2_r), .pll2_presc_mode_o(p2_ps),
        .pll2_b_cnt_o(p2_b), .pll2_a_cnt_o(p2_a)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_cyc(6);
        m_scl = 1'b1; wait_cyc(HALF);
        m_sda = 1'b0; wait_cyc(HALF);
        m_scl = 1'b0; wait_cyc(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_cyc(HALF);
        m_scl = 1'b1; wait_cyc(HALF);
        m_sda = 1'b1; wait_cyc(HALF);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    wait_cyc(HALF);
        m_scl = 1'b1; wait_cyc(HALF);
        m_scl = 1'b0; wait_cyc(2);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; wait_cyc(HALF);
        pre_ack_pull = pull;
        m_scl = 1'b1; wait_cyc(HALF / 2);
        acked = (bus_sda == 1'b0);
        wait_cyc(HALF / 2);
        m_scl = 1'b0; wait_cyc(2);
    endtask

    task automatic put_word(input logic [23:0] w, output int acks);
        bit a;
        acks = 0;
        for (int k = 2; k >= 0; k--) begin
            put_byte(w[8*k +: 8], a);
            if (a) acks++;
        end
    endtask

    task automatic t_reset();
        chk("R1 pull", pull, 0);
        chk("R1 fields", {p1_pol, p1_r, p1_ps, p1_b, p1_a, p2_pol, p2_r, p2_ps, p2_b, p2_a}, 0);
    endtask

    task automatic t_addr_match();
        bit a;
        for (int s = 0; s < 4; s++) begin
            sel = 2'(s);
            bus_start();
            put_byte(8'hC0 | 8'(s << 1), a);
            chk("R3 address ack", a, 1);
            bus_stop();
        end
    endtask

    task automatic t_ref2();
        bit a; int n;
        sel = 2'd2;
        bus_start();
        put_byte(8'hC4, a);
        put_word(24'h020100, n);           // pol=1, R=64, select 00
        chk("R5 data acks", n, 3);
        chk("R11 pull low before ack pulse", pre_ack_pull, 1);
        wait_cyc(6);
        chk("R11 pull released after ack", pull, 0);
        chk("R6 commit before stop", p2_r, 64);
        chk("R8 polarity", p2_pol, 1);
        chk("R7 other regs untouched", {p1_r, p2_b, p1_b}, 0);
        bus_stop();
    endtask

    task automatic t_multi();
        bit a; int n;
        sel = 2'd3;
        bus_start();
        put_byte(8'hC6, a);
        put_word(24'h020881, n);           // main2: B=260, A=32
        chk("R9 main2 B", p2_b, 260);
        chk("R9 main2 A", p2_a, 32);
        chk("R9 main2 presc", p2_ps, 0);
        put_word(24'h000042, n);           // ref1: R=16, pol=0
        chk("R7 ref1 R", p1_r, 16);
        chk("R7 ref2 kept", p2_r, 64);
        put_word(24'h10C633, n);           // main1: presc=1, B=99, A=12
        chk("R6 third word in one transfer", n, 3);
        chk("R9 main1 B", p1_b, 99);
        chk("R9 main1 A", p1_a, 12);
        chk("R9 main1 presc", p1_ps, 1);
        chk("R7 main2 kept", p2_b, 260);
        bus_stop();
    endtask

    task automatic t_dontcare();
        bit a; int n;
        bus_start();
        put_byte(8'hC6, a);
        put_word(24'hFC0016, n);           // ref1 with bits 23:18 set, R=5, pol=0
        chk("R8 ignored bits R", p1_r, 5);
        chk("R8 ignored bits pol", p1_pol, 0);
        put_word(24'hE00601, n);           // main2 with bits 23:21 set, B=3, A=0
        chk("R9 ignored bits presc", p2_ps, 0);
        chk("R9 ignored bits B", p2_b, 3);
        chk("R9 ignored bits A", p2_a, 0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit a; int n;
        sel = 2'd1;
        bus_start();
        put_byte(8'hC0, a);
        chk("R4 no ack on wrong address", a, 0);
        put_word(24'h000ABC, n);           // would hit ref2
        chk("R4 no ack on later bytes", n, 0);
        chk("R4 ref2 unchanged", p2_r, 64);
        bus_stop();
    endtask

    task automatic t_after_stop();
        bit a;
        put_byte(8'hC2, a);                // no start before it
        chk("R2 no ack after stop", a, 0);
        m_sda = 1'b1; wait_cyc(HALF);
        m_scl = 1'b1; wait_cyc(HALF);
    endtask

    task automatic t_restart();
        bit a; int n;
        bus_start();
        put_byte(8'hC2, a);
        put_byte(8'hAA, a);
        put_byte(8'hAA, a);                // two bytes of an abandoned word
        for (int i = 0; i < 4; i++) put_bit(1'b1); // partial byte
        bus_start();                       // repeated start
        put_byte(8'hC2, a);
        chk("R10 address after restart", a, 1);
        put_word(24'h000190, n);           // ref2: R=100, pol=0
        chk("R10 fresh word R", p2_r, 100);
        chk("R10 fresh word pol", p2_pol, 0);
        chk("R10 acks", n, 3);
        bus_stop();
    endtask

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(5);
        t_reset();
        t_addr_match();
        t_ref2();
        t_multi();
        t_dontcare();
        t_mismatch();
        t_after_stop();
        t_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule